// File: doc/BRIEF.md
# Cascadable presettable up/down counter

A small binary counter stage that moves one step up or down on each rising clock edge while its active-low carry input is low. The direction comes from a single level input (1 = up, 0 = down). A parallel load path puts any value into the stage, and a reset clears it. Both of these act at once, without waiting for an edge, and both stop counting while they are held.

The stage drives an active-low carry output. This output goes low only when the stage is about to wrap in the chosen direction and the stage is itself enabled. Several stages share one clock. Each stage's carry output drives the carry input of the next, more significant stage, so a chain of N stages counts as one counter of N times the stage width. The carry output is combinational, so the enable ripples through the chain within the same cycle.

Top module: `udc_stage`

## Requirements
- R1: While `rst` is 1, `count` reads 0 without waiting for a clock edge, and it is still 0 after the edge at which `rst` is released. Reset takes priority over load and counting.
- R2: While `load` is 1 (and `rst` is 0), `count` shows `load_val` at once. The value is captured at the next rising edge and counting is blocked. `load` must be held across at least one rising edge.
- R3: With `rst`=0, `load`=0, `cin_n`=0 and `up`=1, each rising edge adds 1 to `count`, and the maximum value wraps to 0.
- R4: With `rst`=0, `load`=0, `cin_n`=0 and `up`=0, each rising edge subtracts 1 from `count`, and 0 wraps to the maximum value.
- R5: With `cin_n`=1 (and no reset or load), `count` does not change across rising edges.
- R6: With `up`=1, `cout_n` is 0 exactly when `count` is all ones and `cin_n` is 0. Otherwise it is 1. It follows its inputs within the same cycle.
- R7: With `up`=0, `cout_n` is 0 exactly when `count` is 0 and `cin_n` is 0. Otherwise it is 1.
- R8: Bit 0 of `count` is the least significant bit. Two stages that share the clock, with the low stage's `cout_n` driving the high stage's `cin_n`, count as one counter of twice the width, in both directions and across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Asynchronous parallel load, active high |
| load_val | input | WIDTH | Value placed into the counter by `load` |
| up | input | 1 | Direction: 1 up, 0 down |
| cin_n | input | 1 | Count enable from the previous stage, active low |
| count | output | WIDTH | Counter value, bit 0 least significant |
| cout_n | output | 1 | Terminal-count carry to the next stage, active low |

## Verification
The clocked properties assume that `load` and `rst` are synchronous to the clock in practice: each load pulse spans a rising edge, and `up` and `cin_n` change away from the edge. The step properties therefore compare `count` with its value one edge earlier only when no load was pending. The bench drives every input on the falling edge and holds it through the following rising edge. It checks the carry output in mid-cycle and the count just after the edge. Random load and reset pulses always last a full cycle, so the same model covers the immediate view and the captured value.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_CLEAR,
        ACT_LOAD,
        ACT_COUNT,
        ACT_HOLD
    } action_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic stall;
    } ctrl_t;

    function automatic action_e pick_action(input ctrl_t c);
        if (c.clear)      return ACT_CLEAR;
        else if (c.load)  return ACT_LOAD;
        else if (c.stall) return ACT_HOLD;
        else              return ACT_COUNT;
    endfunction

endpackage

// File: rtl/udc_step.sv
module udc_step #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0]  cur,
    input  logic [WIDTH-1:0]  load_val,
    input  udc_pkg::dir_e     dir,
    input  udc_pkg::action_e  act,
    output logic [WIDTH-1:0]  nxt
);
    import udc_pkg::*;

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (act)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = load_val;
            ACT_COUNT: nxt = (dir == DIR_UP) ? cur + ONE : cur - ONE;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/udc_term.sv
module udc_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    input  udc_pkg::dir_e    dir,
    input  logic             cin_n,
    output logic             cout_n
);
    import udc_pkg::*;

    logic at_top;
    logic at_bottom;

    assign at_top    = &value;
    assign at_bottom = ~|value;

    always_comb begin
        if (cin_n)
            cout_n = 1'b1;
        else if (dir == DIR_UP)
            cout_n = ~at_top;
        else
            cout_n = ~at_bottom;
    end
endmodule

// File: rtl/udc_stage.sv
module udc_stage #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             up,
    input  logic             cin_n,
    output logic [WIDTH-1:0] count,
    output logic             cout_n
);
    import udc_pkg::*;

    ctrl_t            ctrl;
    action_e          act;
    dir_e             dir;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    assign ctrl = '{clear: rst, load: load, stall: cin_n};
    assign act  = pick_action(ctrl);
    assign dir  = up ? DIR_UP : DIR_DOWN;

    udc_step #(.WIDTH(WIDTH)) u_step (
        .cur      (cnt_q),
        .load_val (load_val),
        .dir      (dir),
        .act      (act),
        .nxt      (cnt_d)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // load overrides the visible value at once; the register catches it at the edge
    assign count = (act == ACT_LOAD) ? load_val : cnt_q;

    udc_term #(.WIDTH(WIDTH)) u_term (
        .value  (count),
        .dir    (dir),
        .cin_n  (cin_n),
        .cout_n (cout_n)
    );
endmodule

// File: rtl/udc_stage_checker.sv
module udc_stage_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic [WIDTH-1:0] load_val,
    input logic             up,
    input logic             cin_n,
    input logic [WIDTH-1:0] count,
    input logic             cout_n
);
    localparam logic [WIDTH-1:0] ALL1 = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_reset_zero_r1: assert (count == '0)
                else $error("reset did not clear count");
        end else if (load) begin
            p_load_visible_r2: assert (count == load_val)
                else $error("load value not visible");
        end
    end

    p_count_up_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && up) |=> (load || count == WIDTH'($past(count) + 1'b1)));

    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !cin_n && !up) |=> (load || count == WIDTH'($past(count) - 1'b1)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cin_n) |=> (load || $stable(count)));

    p_cout_up_r6: assert property (@(posedge clk) disable iff (rst)
        up |-> (cout_n == !(!cin_n && count == ALL1)));

    p_cout_down_r7: assert property (@(posedge clk) disable iff (rst)
        !up |-> (cout_n == !(!cin_n && count == '0)));
endmodule

bind udc_stage udc_stage_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/udc_stage_test.sv
module udc_stage_test;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic [7:0]   val = '0;
    logic         up = 1'b1;
    logic         cin_n = 1'b0;
    logic [W-1:0] cnt_lo, cnt_hi;
    logic         co_lo, co_hi;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    udc_stage #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .load(load), .load_val(val[3:0]),
        .up(up), .cin_n(cin_n), .count(cnt_lo), .cout_n(co_lo)
    );
    udc_stage #(.WIDTH(W)) u_hi (
        .clk(clk), .rst(rst), .load(load), .load_val(val[7:4]),
        .up(up), .cin_n(co_lo), .count(cnt_hi), .cout_n(co_hi)
    );

    function automatic logic exp_cout(input logic [3:0] c, input logic u, input logic ci);
        if (ci) return 1'b1;
        return u ? !(c == 4'hF) : !(c == 4'h0);
    endfunction

    function automatic logic [7:0] exp_next(input logic [7:0] m, input logic r,
                                            input logic l, input logic [7:0] v,
                                            input logic u, input logic ci);
        if (r)  return 8'h00;
        if (l)  return v;
        if (ci) return m;
        return u ? m + 8'h01 : m - 8'h01;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic [7:0] v,
                        input logic u, input logic ci);
        logic [7:0] vis;
        string tc, tn;
        @(negedge clk);
        rst = r; load = l; val = v; up = u; cin_n = ci;
        #1;
        vis = r ? 8'h00 : (l ? v : model);
        tc = u ? "R6" : "R7";
        chk(r ? "R1 immediate" : (l ? "R2 immediate" : "R8 view"), {cnt_hi, cnt_lo}, vis);
        if (!r) begin
            chk({tc, " low stage"}, co_lo, exp_cout(vis[3:0], u, ci));
            chk({tc, " high stage"}, co_hi, exp_cout(vis[7:4], u, exp_cout(vis[3:0], u, ci)));
        end
        @(posedge clk);
        model = exp_next(model, r, l, v, u, ci);
        #1;
        if (r)       tn = "R1";
        else if (l)  tn = "R2";
        else if (ci) tn = "R5";
        else if (u)  tn = "R3 R8";
        else         tn = "R4 R8";
        chk(tn, {cnt_hi, cnt_lo}, model);
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        #1;
        chk("R1 reset state", {cnt_hi, cnt_lo}, 8'h00);
        step(1, 0, 8'h00, 1, 0);
        // load near the top, then count up through the 8-bit wrap
        step(0, 1, 8'hFD, 1, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 1, 0);
        // load near zero, count down through the wrap
        step(0, 1, 8'h02, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 8'h00, 0, 0);
        // carry-in high holds in both directions
        step(0, 0, 8'h00, 1, 1);
        step(0, 0, 8'h00, 0, 1);
        // reset dominates load
        step(1, 1, 8'hA5, 1, 0);
        // reset asserted in mid-cycle clears before the edge
        step(0, 1, 8'h3C, 1, 0);
        @(negedge clk);
        rst = 1'b1; load = 1'b0;
        #1;
        chk("R1 async clear", {cnt_hi, cnt_lo}, 8'h00);
        @(posedge clk);
        model = 8'h00;
        // fixed-seed random mix
        void'($urandom(32'h5EED));
        for (int i = 0; i < 600; i++) begin
            logic r, l, u, ci;
            r  = ($urandom % 40) == 0;
            l  = ($urandom % 10) == 0;
            u  = ($urandom % 2) == 1;
            ci = ($urandom % 5) == 0;
            step(r, l, 8'($urandom), u, ci);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule